// File: doc/BRIEF.md
# Access Fault Status and Frame Builder

This block sits beside a CPU core's address translation and bus logic. It records the most recent access fault and, when the core's exception sequencer asks for it, writes the long access-fault exception frame onto the supervisor stack. The block accepts two kinds of fault. A translation fault comes from the table walk. A physical bus error comes from the memory system. Each fault carries the access size, the direction, the privilege level, whether it was an instruction fetch, and the faulting address. The block packs these into a 16-bit status word and holds the address alongside it.

A one-cycle start pulse supplies the current stack pointer, the return PC and the saved status register. The block then issues a fixed sequence of 18 pre-decrementing writes through a simple valid/ready memory port, one word or longword per accepted beat. The first 15 beats form the frame body, which holds zeroed write-back and push-data slots, the fault address, the status word and the effective address. The last 3 beats form a standard exception header with format 7 and vector 2.

When the last beat is accepted, a done pulse reports the new stack pointer. A fault that arrives while a frame is still being written cannot be reported. In that case the block stops writing and raises a sticky halt output.

Top module: `access_fault_framer`

## Requirements
- R1: A translation fault taken while no frame is in progress sets the status word as follows. Bit 10 is 1. Bit 8 is 1 for a read and 0 for a write. Bits 6:5 hold the size code. Bit 2 is 1 for supervisor. Bit 1 is 1 for an instruction fetch. Bit 0 is 1 for a data access. Every other bit is 0. The fault address output takes the access address.
- R2: The size input encodes 0=byte, 1=word, 2=longword and 3=line. These map to status bits 6:5 as 01, 10, 00 and 11.
- R3: A bus error taken while no frame is in progress clears bits 6:5 and 2:0, then fills them as in R1. It sets bit 10, sets bit 8 on a read, and leaves bit 8 and all other bits unchanged on a write. It latches its address as the fault address. When both fault kinds arrive in the same cycle, the translation fault wins.
- R4: A start pulse accepted while idle first forces the stack pointer even. The block then writes its items with pre-decrement, each beat at the old pointer minus 4 for a longword or minus 2 for a word. The body is written in this order: eight zero longwords, the fault address as a longword twice, three zero words, the status word as a word, and the fault address as the effective-address longword. Every write address is even.
- R5: After the body come three header items in order. The first is the word 0x7008 (format 7 in bits 15:12, vector 2 times 4). The second is the return PC as a longword. The third is the saved status register as a word. Word items carry their value in data bits 15:0, with bits 31:16 at zero.
- R6: done_o is high for exactly one cycle, in the cycle after the final write is accepted. In that cycle sp_o equals the even starting pointer minus 60.
- R7: While wr_valid_o is high and wr_ready_i is low, the address, data and size of the pending write stay unchanged into the next cycle.
- R8: A fault of either kind that arrives while a frame is being written sets halt_o. halt_o stays set until reset. wr_valid_o is 0 from the next cycle on. That fault does not change the status word or the fault address.
- R9: A start pulse is ignored while a frame is in progress and while halt_o is set.
- R10: After reset, wr_valid_o, done_o and halt_o are 0, and the status word and fault address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_fault_i | input | 1 | Translation fault strobe |
| bus_err_i | input | 1 | Physical bus error strobe |
| acc_size_i | input | 2 | Access size: 0 byte, 1 word, 2 long, 3 line |
| acc_write_i | input | 1 | 1 for a write access |
| acc_super_i | input | 1 | 1 for a supervisor access |
| acc_code_i | input | 1 | 1 for an instruction fetch |
| acc_addr_i | input | 32 | Faulting address |
| start_i | input | 1 | Start building the frame |
| sp_i | input | 32 | Stack pointer at start |
| pc_i | input | 32 | Return PC for the header |
| sr_i | input | 16 | Saved status register for the header |
| wr_valid_o | output | 1 | Write request |
| wr_ready_i | input | 1 | Write accepted this cycle |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data, word in bits 15:0 |
| wr_long_o | output | 1 | 1 longword, 0 word |
| done_o | output | 1 | Frame complete pulse |
| sp_o | output | 32 | Final stack pointer |
| status_o | output | 16 | Fault status word |
| fault_addr_o | output | 32 | Latched fault address |
| halt_o | output | 1 | Double-fault halt, sticky |

## Verification
A wrong beat counter shows at the ports on the first bad beat. The item at that step has the wrong data or width. A wrong width also shifts every later address by 2, so the error spreads through the rest of the frame, and sp_o is then off when done_o fires. A corrupted status register shows on status_o one cycle after the fault. The same value reappears in beat 13 of the next frame.

If the in-progress flag is lost, a fault during a frame does not raise halt_o. That fault then overwrites status_o one cycle later, in the middle of the frame. Random backpressure catches any request that changes while stalled, on the cycle right after the stall.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int unsigned SSW_W = 16;
  localparam int BIT_ATC = 10;
  localparam int BIT_RW = 8;
  localparam int SIZE_LO = 5;
  localparam int TM_SUP = 2;
  localparam int TM_CODE = 1;
  localparam int TM_DATA = 0;
  localparam logic [SSW_W-1:0] SIZE_MASK = 16'h0060;
  localparam logic [SSW_W-1:0] TM_MASK = 16'h0007;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_LONG = 2'd2,
    ACC_LINE = 2'd3
  } acc_size_e;

  function automatic logic [1:0] size_code(input acc_size_e s);
    case (s)
      ACC_BYTE: size_code = 2'b01;
      ACC_WORD: size_code = 2'b10;
      ACC_LONG: size_code = 2'b00;
      default:  size_code = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/afs_status.sv
module afs_status
  import afs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xlat_i,
  input  logic             berr_i,
  input  logic             lock_i,
  input  logic [1:0]       size_i,
  input  logic             write_i,
  input  logic             super_i,
  input  logic             code_i,
  input  logic [AW-1:0]    addr_i,
  output logic [SSW_W-1:0] ssw_o,
  output logic [AW-1:0]    far_o,
  output logic             nested_o
);
  logic [SSW_W-1:0] ssw_q, fields, ssw_d;
  logic [AW-1:0]    far_q;
  logic             take;

  always_comb begin
    fields = '0;
    fields[BIT_ATC] = 1'b1;
    fields[BIT_RW] = ~write_i;
    fields[SIZE_LO +: 2] = size_code(acc_size_e'(size_i));
    fields[TM_SUP] = super_i;
    fields[TM_CODE] = code_i;
    fields[TM_DATA] = ~code_i;
  end

  // translation fault rebuilds the word; bus error merges into it
  always_comb begin
    if (xlat_i) ssw_d = fields;
    else        ssw_d = (ssw_q & ~(SIZE_MASK | TM_MASK)) | fields;
  end

  assign take = (xlat_i | berr_i) & ~lock_i;
  assign nested_o = (xlat_i | berr_i) & lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssw_q <= '0;
      far_q <= '0;
    end else if (take) begin
      ssw_q <= ssw_d;
      far_q <= addr_i;
    end
  end

  assign ssw_o = ssw_q;
  assign far_o = far_q;
endmodule

// File: rtl/afs_push_ptr.sv
module afs_push_ptr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] sp_i,
  input  logic          adv_i,
  input  logic          long_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LONG_B = AW'(4);
  localparam logic [AW-1:0] WORD_B = AW'(2);
  localparam logic [AW-1:0] EVEN_M = ~AW'(1);

  logic [AW-1:0] ptr_q;

  assign addr_o = ptr_q - (long_i ? LONG_B : WORD_B);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= sp_i & EVEN_M;
    else if (adv_i)  ptr_q <= addr_o;
  end
endmodule

// File: rtl/afs_frame_seq.sv
module afs_frame_seq
  import afs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ZERO_LONGS = 8,
  parameter int ZERO_WORDS = 3,
  parameter int FMT        = 7,
  parameter int VEC        = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             ready_i,
  input  logic [AW-1:0]    far_i,
  input  logic [SSW_W-1:0] ssw_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [15:0]      sr_i,
  output logic             valid_o,
  output logic             long_o,
  output logic [AW-1:0]    data_o,
  output logic             last_o
);
  localparam int S_FAR0  = ZERO_LONGS;
  localparam int S_FAR1  = S_FAR0 + 1;
  localparam int S_ZW    = S_FAR1 + 1;
  localparam int S_SSW   = S_ZW + ZERO_WORDS;
  localparam int S_EA    = S_SSW + 1;
  localparam int S_FMT   = S_EA + 1;
  localparam int S_PC    = S_FMT + 1;
  localparam int S_SR    = S_PC + 1;
  localparam int N_STEPS = S_SR + 1;
  localparam int STEP_W  = $clog2(N_STEPS);
  localparam logic [15:0] FMT_WORD = 16'((FMT << 12) | (VEC << 2));

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [AW-1:0]     pc_q;
  logic [15:0]       sr_q;
  logic              accept;
  int                step;

  assign step   = int'(step_q);
  assign accept = busy_q & ready_i;
  assign last_o = accept & (step == S_SR);

  always_comb begin
    long_o = 1'b1;
    data_o = '0;
    if (step < S_FAR0) begin
      long_o = 1'b1;
    end else if (step <= S_FAR1) begin
      data_o = far_i;
    end else if (step < S_SSW) begin
      long_o = 1'b0;
    end else if (step == S_SSW) begin
      long_o = 1'b0;
      data_o = AW'(ssw_i);
    end else if (step == S_EA) begin
      data_o = far_i;
    end else if (step == S_FMT) begin
      long_o = 1'b0;
      data_o = AW'(FMT_WORD);
    end else if (step == S_PC) begin
      data_o = pc_q;
    end else begin
      long_o = 1'b0;
      data_o = AW'(sr_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      pc_q   <= '0;
      sr_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      step_q <= '0;
      pc_q   <= pc_i;
      sr_q   <= sr_i;
    end else if (accept) begin
      if (step == S_SR) busy_q <= 1'b0;
      step_q <= step_q + STEP_W'(1);
    end
  end

  assign valid_o = busy_q;
endmodule

// File: rtl/access_fault_framer.sv
module access_fault_framer
  import afs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xlat_fault_i,
  input  logic          bus_err_i,
  input  logic [1:0]    acc_size_i,
  input  logic          acc_write_i,
  input  logic          acc_super_i,
  input  logic          acc_code_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          start_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [15:0]   sr_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] wr_data_o,
  output logic          wr_long_o,
  output logic          done_o,
  output logic [AW-1:0] sp_o,
  output logic [15:0]   status_o,
  output logic [AW-1:0] fault_addr_o,
  output logic          halt_o
);
  logic             busy, nested, go, last, is_long;
  logic             halt_q, done_q;
  logic [SSW_W-1:0] ssw;
  logic [AW-1:0]    far, data, addr, ptr;

  assign go = start_i & ~busy & ~halt_q;

  afs_status #(.AW(AW)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xlat_i   (xlat_fault_i),
    .berr_i   (bus_err_i),
    .lock_i   (busy),
    .size_i   (acc_size_i),
    .write_i  (acc_write_i),
    .super_i  (acc_super_i),
    .code_i   (acc_code_i),
    .addr_i   (acc_addr_i),
    .ssw_o    (ssw),
    .far_o    (far),
    .nested_o (nested)
  );

  afs_frame_seq #(.AW(AW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go),
    .abort_i (nested),
    .ready_i (wr_ready_i),
    .far_i   (far),
    .ssw_i   (ssw),
    .pc_i    (pc_i),
    .sr_i    (sr_i),
    .valid_o (busy),
    .long_o  (is_long),
    .data_o  (data),
    .last_o  (last)
  );

  afs_push_ptr #(.AW(AW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .sp_i   (sp_i),
    .adv_i  (busy & wr_ready_i),
    .long_i (is_long),
    .addr_o (addr),
    .ptr_o  (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      halt_q <= halt_q | nested;
      done_q <= last & ~nested;
    end
  end

  assign wr_valid_o   = busy;
  assign wr_addr_o    = addr;
  assign wr_data_o    = data;
  assign wr_long_o    = is_long;
  assign done_o       = done_q;
  assign sp_o         = ptr;
  assign status_o     = ssw;
  assign fault_addr_o = far;
  assign halt_o       = halt_q;
endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xlat_fault_i,
  input logic          bus_err_i,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [AW-1:0] wr_data_o,
  input logic          wr_long_o,
  input logic          done_o,
  input logic [15:0]   status_o,
  input logic          halt_o
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i && !xlat_fault_i && !bus_err_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_long_o)));

  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  p_halt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !wr_valid_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_valid_o && wr_ready_i));

  p_even_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !wr_addr_o[0]);

  p_atc_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlat_fault_i && !wr_valid_o && !halt_o) |=> status_o[10]);
endmodule

bind access_fault_framer afs_checker #(.AW(AW)) u_afs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xlat_fault_i (xlat_fault_i),
  .bus_err_i    (bus_err_i),
  .wr_valid_o   (wr_valid_o),
  .wr_ready_i   (wr_ready_i),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .wr_long_o    (wr_long_o),
  .done_o       (done_o),
  .status_o     (status_o),
  .halt_o       (halt_o)
);

// File: tb/access_fault_framer_bench.sv
module access_fault_framer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xlat_fault_i = 1'b0, bus_err_i = 1'b0;
  logic [1:0]  acc_size_i = '0;
  logic        acc_write_i = 1'b0, acc_super_i = 1'b0, acc_code_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        start_i = 1'b0;
  logic [31:0] sp_i = '0, pc_i = '0;
  logic [15:0] sr_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b0, wr_long_o, done_o, halt_o;
  logic [31:0] wr_addr_o, wr_data_o, sp_o, fault_addr_o;
  logic [15:0] status_o;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_ssw;
  logic [31:0] m_far;

  always #5 clk_i = ~clk_i;

  access_fault_framer u_access_fault_framer (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [1:0] sz, input logic wr, input logic sup, input logic cod);
    logic [1:0] f;
    case (sz)
      2'd0: f = 2'b01;
      2'd1: f = 2'b10;
      2'd2: f = 2'b00;
      default: f = 2'b11;
    endcase
    return 16'h0400 | (wr ? 16'h0 : 16'h0100) | {9'b0, f, 2'b0, sup, cod, ~cod};
  endfunction

  function automatic void exp_item(input int k, input logic [31:0] far, input logic [15:0] ssw,
                                   input logic [31:0] pc, input logic [15:0] sr,
                                   output logic lng, output logic [31:0] d);
    lng = 1'b1; d = '0;
    if (k < 8) d = '0;
    else if (k < 10) d = far;
    else if (k < 13) lng = 1'b0;
    else if (k == 13) begin lng = 1'b0; d = {16'b0, ssw}; end
    else if (k == 14) d = far;
    else if (k == 15) begin lng = 1'b0; d = 32'h0000_7008; end
    else if (k == 16) d = pc;
    else begin lng = 1'b0; d = {16'b0, sr}; end
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_ssw = '0; m_far = '0;
    @(negedge clk_i);
  endtask

  // kind: 0 xlat, 1 bus error, 2 both
  task automatic fault(input int kind, input logic [1:0] sz, input logic wr, input logic sup,
                       input logic cod, input logic [31:0] a);
    xlat_fault_i = (kind != 1); bus_err_i = (kind != 0);
    acc_size_i = sz; acc_write_i = wr; acc_super_i = sup; acc_code_i = cod; acc_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    xlat_fault_i = 1'b0; bus_err_i = 1'b0;
    if (kind == 1) m_ssw = (m_ssw & 16'hFF98) | enc(sz, wr, sup, cod);
    else m_ssw = enc(sz, wr, sup, cod);
    m_far = a;
    chk(status_o == m_ssw, kind == 1 ? "R3 status" : "R1/R2 status", 32'(status_o), 32'(m_ssw));
    chk(fault_addr_o == m_far, kind == 1 ? "R3 address" : "R1 address", fault_addr_o, m_far);
  endtask

  task automatic run_frame(input logic [31:0] sp, input logic [31:0] pc, input logic [15:0] sr,
                           input int prob, input bit poke);
    logic [31:0] ptr, pa, pd, d;
    logic pl, lng, prev_stall, rdy;
    int k, guard;
    sp_i = sp; pc_i = pc; sr_i = sr; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    ptr = sp & ~32'd1;
    k = 0; guard = 0; prev_stall = 1'b0; pa = '0; pd = '0; pl = 1'b0;
    while (k < 18 && guard < 3000) begin
      if (prev_stall)
        chk(wr_valid_o && wr_addr_o == pa && wr_data_o == pd && wr_long_o == pl, "R7 stall hold", wr_addr_o, pa);
      if (poke && k == 3) begin
        start_i = 1'b1; sp_i = 32'h0000_4000; pc_i = 32'hDEAD_0000;
      end else start_i = 1'b0;
      rdy = (($urandom % 100) < prob);
      if (wr_valid_o && rdy) begin
        exp_item(k, m_far, m_ssw, pc, sr, lng, d);
        ptr = ptr - (lng ? 32'd4 : 32'd2);
        chk(wr_addr_o == ptr, k < 15 ? "R4 addr" : "R5 addr", wr_addr_o, ptr);
        chk(wr_data_o == d && wr_long_o == lng, k < 15 ? "R4 item" : "R5 header", wr_data_o, d);
        k++;
      end
      prev_stall = wr_valid_o && !rdy;
      pa = wr_addr_o; pd = wr_data_o; pl = wr_long_o;
      wr_ready_i = rdy;
      @(posedge clk_i); @(negedge clk_i);
      guard++;
    end
    wr_ready_i = 1'b0; start_i = 1'b0;
    chk(done_o == 1'b1, "R6 done", 32'(done_o), 32'd1);
    chk(sp_o == (sp & ~32'd1) - 32'd60, "R6 final sp", sp_o, (sp & ~32'd1) - 32'd60);
    chk(!wr_valid_o, "R4 no extra write", 32'(wr_valid_o), 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(done_o == 1'b0, "R6 single pulse", 32'(done_o), 0);
  endtask

  initial begin
    void'($urandom(32'd20250));
    do_reset();
    chk(!wr_valid_o && !done_o && !halt_o, "R10 reset outputs", {wr_valid_o, done_o, halt_o}, 0);
    chk(status_o == 0 && fault_addr_o == 0, "R10 reset status", 32'(status_o), 0);

    fault(0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1234_5678);
    fault(0, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000_0100);
    fault(0, 2'd2, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC);
    fault(0, 2'd3, 1'b1, 1'b0, 1'b1, 32'h8000_0000);
    // bus error after write: RW set by read
    fault(1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0ABC);
    // bus error write after read: RW kept
    fault(0, 2'd2, 1'b0, 1'b1, 1'b1, 32'h5555_0000);
    fault(1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_2222);
    // both at once: translation wins
    fault(2, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0000_3333);

    run_frame(32'h0001_0001, 32'h0040_0010, 16'h2704, 100, 1'b0);
    run_frame(32'h0002_0000, 32'h00AB_CDEF, 16'h0010, 40, 1'b1);

    for (int i = 0; i < 6; i++) begin
      fault(int'($urandom % 3), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), $urandom);
      run_frame($urandom | 32'h0000_1000, $urandom, 16'($urandom), 60, 1'($urandom));
    end

    // nested fault halts
    fault(0, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0000_7777);
    sp_i = 32'h0000_8000; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0; wr_ready_i = 1'b1;
    repeat (5) begin @(posedge clk_i); @(negedge clk_i); end
    wr_ready_i = 1'b0;
    xlat_fault_i = 1'b1; acc_addr_i = 32'h0BAD_0000; acc_write_i = 1'b1; acc_size_i = 2'd3;
    @(posedge clk_i); @(negedge clk_i);
    xlat_fault_i = 1'b0;
    chk(halt_o == 1'b1, "R8 halt", 32'(halt_o), 1);
    chk(!wr_valid_o, "R8 writes stop", 32'(wr_valid_o), 0);
    chk(status_o == m_ssw && fault_addr_o == m_far, "R8 status frozen", fault_addr_o, m_far);
    start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) begin @(posedge clk_i); @(negedge clk_i); end
    chk(halt_o == 1'b1, "R8 halt sticky", 32'(halt_o), 1);
    chk(!wr_valid_o, "R9 start ignored in halt", 32'(wr_valid_o), 0);

    do_reset();
    chk(!halt_o && !wr_valid_o && status_o == 0, "R10 reset clears halt", 32'(halt_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule